// File: doc/BRIEF.md
# Smart-card serial status flags

This block keeps two status flags for a half-duplex smart-card style serial channel. The first is a receive parity-error flag. The second is a transmit-end flag. It also drives the blocking signals that follow from them. The serial shifter, the line sampling and the data registers live elsewhere. This block only sees pulses from those parts and gives back flag and control levels.

The parity-error flag is set when the receive path reports a bad parity while reception is enabled. The received byte still moves to the data register, but the receive-full indication is held off. Further reception is frozen while the flag is up. In clocked synchronous operation, transmission is frozen as well. Software clears the flag with a two-step sequence: a status read that returns it as 1, then a write of 0.

The transmit-end flag rises a fixed number of half elementary-time-unit steps after a byte leaves the shifter. That count depends on the two mode bits. The flag only rises if, at that point, the transmit data register is empty and no error signal has come back from the card. It is also held at 1 while the transmitter is disabled and no error signal is pending.

Top module: `scf_status_flags`

## Requirements
- R1: A cycle with `par_err`=1 and `re`=1 sets `per` at the next clock edge. With `re`=0, `par_err` leaves `per` at 0.
- R2: `rx_full_inhibit` is 1 in the cycle where a parity error is accepted (`par_err`=1, `re`=1) and in every cycle where `per` is 1. Otherwise it is 0.
- R3: `rx_block` equals `per`. `tx_block` equals `per` when `sync_mode`=1 and is 0 when `sync_mode`=0.
- R4: `per` clears only on a write (`reg_wr`=1) with `wr_per`=0, and only when the most recent status read (`reg_rd`) since the last write returned `per`=1. In all of these cases `per` stays 1:
  - a write of 1;
  - a write of 0 with no qualifying read;
  - a write of 0 after a read that returned 0.
  Any write consumes the read. An accepted parity error in the same cycle as a clearing write wins.
- R5: Dropping `re` to 0 leaves `per` unchanged.
- R6: While `te`=0 and `err_sig`=0, `tend` is 1 from the next clock edge onwards. With `te`=0 and `err_sig`=1, `tend` holds its value.
- R7: A cycle with `tdr_wr`=1 and `te`=1 clears `tend` at the next edge.
- R8: The delay after a `tx_done` pulse counts `half_tick` pulses that arrive after the `tx_done` cycle. The mode bits are sampled at `tx_done`:
  - `gm`=0, `blk`=0: 5 pulses (2.5 etu);
  - `gm`=0, `blk`=1: 3 pulses (1.5 etu);
  - `gm`=1: 2 pulses (1.0 etu), whatever `blk` is.

  `tend` can rise at the edge that ends the last counted pulse, and not earlier.
- R9: When the delay ends, `tend` is set only if `tdr_empty`=1 and `err_sig`=0 in that cycle. Otherwise it stays 0.
- R10: Synchronous reset `rst` gives `per`=0, `tend`=1, and clears both the read qualifier and the delay counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | One-cycle pulse per half elementary time unit |
| tx_done | input | 1 | One-cycle pulse at the end of a byte transmission |
| err_sig | input | 1 | Error signal received from the card (level) |
| par_err | input | 1 | Parity error pulse from the receive path |
| tdr_empty | input | 1 | Transmit data register is empty |
| tdr_wr | input | 1 | Write strobe into the transmit data register |
| te | input | 1 | Transmit enable |
| re | input | 1 | Receive enable |
| gm | input | 1 | Mode bit selecting the shortest delay |
| blk | input | 1 | Mode bit selecting the medium delay |
| sync_mode | input | 1 | Clocked synchronous operation |
| reg_rd | input | 1 | Status register read strobe |
| reg_wr | input | 1 | Status register write strobe |
| wr_per | input | 1 | Data bit written to the parity-error flag |
| per | output | 1 | Parity-error flag |
| tend | output | 1 | Transmit-end flag |
| rx_full_inhibit | output | 1 | Suppresses setting of the receive-full flag |
| rx_block | output | 1 | Freezes further reception |
| tx_block | output | 1 | Freezes further transmission |

## Verification
The assertions assume that these inputs are one-cycle pulses and never overlap in a cycle:
- `reg_rd` with `reg_wr`;
- `tx_done` with `half_tick`.

They also assume that `te` only changes while no delay is in progress. The bench keeps to these rules by driving every strobe for exactly one cycle. It separates each `half_tick` by an idle cycle and sets the mode and enable bits before the `tx_done` pulse of each case. It sweeps both mode bits together with every combination of `tdr_empty` and `err_sig`. Expected flag values are computed from the tick count that each mode selects.

// File: rtl/scf_pkg.sv
package scf_pkg;
  typedef enum logic [1:0] {
    DLY_FULL = 2'd0,
    DLY_BLK  = 2'd1,
    DLY_GM   = 2'd2
  } scf_dly_e;

  function automatic scf_dly_e scf_pick_dly(input logic gm, input logic blk);
    if (gm) return DLY_GM;
    if (blk) return DLY_BLK;
    return DLY_FULL;
  endfunction
endpackage

// File: rtl/scf_per_flag.sv
module scf_per_flag (
  input  logic clk,
  input  logic rst,
  input  logic par_err,
  input  logic re,
  input  logic reg_rd,
  input  logic reg_wr,
  input  logic wr_per,
  output logic per
);
  logic rd_seen;
  logic accept;
  logic clr_ok;

  assign accept = par_err && re;
  assign clr_ok = reg_wr && !wr_per && rd_seen;

  // Qualifier remembers what the last read returned; any write consumes it.
  always_ff @(posedge clk) begin
    if (rst) rd_seen <= 1'b0;
    else if (reg_wr) rd_seen <= 1'b0;
    else if (reg_rd) rd_seen <= per;
  end

  always_ff @(posedge clk) begin
    if (rst) per <= 1'b0;
    else if (accept) per <= 1'b1;
    else if (clr_ok) per <= 1'b0;
  end
endmodule

// File: rtl/scf_tend_unit.sv
module scf_tend_unit #(
  parameter int T_FULL = 5,
  parameter int T_BLK  = 3,
  parameter int T_GM   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  input  logic tx_done,
  input  logic gm,
  input  logic blk,
  input  logic te,
  input  logic err_sig,
  input  logic tdr_empty,
  input  logic tdr_wr,
  output logic tend
);
  import scf_pkg::*;

  localparam int CW = $clog2(T_FULL + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] load_val;
  logic          expire;

  always_comb begin
    case (scf_pick_dly(gm, blk))
      DLY_GM:  load_val = CW'(T_GM);
      DLY_BLK: load_val = CW'(T_BLK);
      default: load_val = CW'(T_FULL);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tx_done) cnt <= load_val;
    else if (half_tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = half_tick && !tx_done && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) tend <= 1'b1;
    else if (!te && !err_sig) tend <= 1'b1;
    else if (expire && tdr_empty && !err_sig) tend <= 1'b1;
    else if (tdr_wr && te) tend <= 1'b0;
  end
endmodule

// File: rtl/scf_status_flags.sv
module scf_status_flags #(
  parameter int T_FULL = 5,
  parameter int T_BLK  = 3,
  parameter int T_GM   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  input  logic tx_done,
  input  logic err_sig,
  input  logic par_err,
  input  logic tdr_empty,
  input  logic tdr_wr,
  input  logic te,
  input  logic re,
  input  logic gm,
  input  logic blk,
  input  logic sync_mode,
  input  logic reg_rd,
  input  logic reg_wr,
  input  logic wr_per,
  output logic per,
  output logic tend,
  output logic rx_full_inhibit,
  output logic rx_block,
  output logic tx_block
);
  scf_per_flag u_per (
    .clk     (clk),
    .rst     (rst),
    .par_err (par_err),
    .re      (re),
    .reg_rd  (reg_rd),
    .reg_wr  (reg_wr),
    .wr_per  (wr_per),
    .per     (per)
  );

  scf_tend_unit #(
    .T_FULL (T_FULL),
    .T_BLK  (T_BLK),
    .T_GM   (T_GM)
  ) u_tend (
    .clk       (clk),
    .rst       (rst),
    .half_tick (half_tick),
    .tx_done   (tx_done),
    .gm        (gm),
    .blk       (blk),
    .te        (te),
    .err_sig   (err_sig),
    .tdr_empty (tdr_empty),
    .tdr_wr    (tdr_wr),
    .tend      (tend)
  );

  assign rx_full_inhibit = (par_err && re) || per;
  assign rx_block        = per;
  assign tx_block        = per && sync_mode;
endmodule

// File: rtl/scf_status_flags_chk.sv
module scf_status_flags_chk (
  input logic clk,
  input logic rst,
  input logic par_err,
  input logic re,
  input logic reg_wr,
  input logic wr_per,
  input logic te,
  input logic err_sig,
  input logic tdr_empty,
  input logic per,
  input logic tend
);
  AST_PER_SET: assert property (@(posedge clk) disable iff (rst)
    (par_err && re) |=> per);  // R1
  AST_PER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (per && !reg_wr) |=> per);  // R4
  AST_PER_CLR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(per) |-> ($past(reg_wr) && !$past(wr_per)));  // R4
  AST_PER_RE_DROP: assert property (@(posedge clk) disable iff (rst)
    ($fell(re) && per && !reg_wr) |=> per);  // R5
  AST_TEND_FORCE: assert property (@(posedge clk) disable iff (rst)
    (!te && !err_sig) |=> tend);  // R6
  AST_TEND_RISE_OK: assert property (@(posedge clk) disable iff (rst)
    ($rose(tend) && $past(te)) |-> ($past(tdr_empty) && !$past(err_sig)));  // R9
endmodule

bind scf_status_flags scf_status_flags_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .par_err   (par_err),
  .re        (re),
  .reg_wr    (reg_wr),
  .wr_per    (wr_per),
  .te        (te),
  .err_sig   (err_sig),
  .tdr_empty (tdr_empty),
  .per       (per),
  .tend      (tend)
);

// File: tb/test_scf_status_flags.sv
module test_scf_status_flags;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_tick = 0, tx_done = 0, err_sig = 0, par_err = 0;
  logic tdr_empty = 0, tdr_wr = 0, te = 0, re = 0, gm = 0, blk = 0;
  logic sync_mode = 0, reg_rd = 0, reg_wr = 0, wr_per = 0;
  logic per, tend, rx_full_inhibit, rx_block, tx_block;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scf_status_flags i_scf_status_flags (
    .clk(clk), .rst(rst), .half_tick(half_tick), .tx_done(tx_done),
    .err_sig(err_sig), .par_err(par_err), .tdr_empty(tdr_empty),
    .tdr_wr(tdr_wr), .te(te), .re(re), .gm(gm), .blk(blk),
    .sync_mode(sync_mode), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .wr_per(wr_per), .per(per), .tend(tend),
    .rx_full_inhibit(rx_full_inhibit), .rx_block(rx_block),
    .tx_block(tx_block)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_read();
    reg_rd = 1; step(); reg_rd = 0;
  endtask

  task automatic do_write(input logic v);
    reg_wr = 1; wr_per = v; step(); reg_wr = 0; wr_per = 0;
  endtask

  task automatic raise_per();
    re = 1; par_err = 1; step(); par_err = 0;
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    step(); step();
    rst = 0;
    step();
    // R10 reset values
    chk("R10 per", per, 1'b0);
    chk("R10 tend", tend, 1'b1);

    // R1 parity error ignored while re=0
    re = 0; par_err = 1; #1;
    chk("R2 inhibit off re=0", rx_full_inhibit, 1'b0);
    step(); par_err = 0;
    chk("R1 ignored re=0", per, 1'b0);

    // R1/R2 accepted error
    re = 1; par_err = 1; #1;
    chk("R2 inhibit on accept", rx_full_inhibit, 1'b1);
    step(); par_err = 0;
    chk("R1 set", per, 1'b1);
    chk("R2 inhibit while per", rx_full_inhibit, 1'b1);
    for (int s = 0; s < 2; s++) begin
      sync_mode = s[0]; #1;
      chk("R3 rx_block", rx_block, 1'b1);
      chk("R3 tx_block", tx_block, s[0]);
    end
    sync_mode = 0;

    // R5 dropping re
    re = 0; step(); step();
    chk("R5 per kept", per, 1'b1);

    // R4 write 0 without read
    do_write(0);
    chk("R4 write0 no read", per, 1'b1);
    // R4 read then write 1, then write 0: read consumed
    do_read(); do_write(1);
    chk("R4 write1", per, 1'b1);
    do_write(0);
    chk("R4 read consumed", per, 1'b1);
    // R4 read then write 0 clears
    do_read(); do_write(0);
    chk("R4 clear", per, 1'b0);
    chk("R3 rx_block low", rx_block, 1'b0);
    chk("R2 inhibit low", rx_full_inhibit, 1'b0);

    // R4 read returned 0 then flag set later
    do_read(); raise_per(); do_write(0);
    chk("R4 stale read 0", per, 1'b1);
    // R4 set wins over clear
    do_read();
    reg_wr = 1; wr_per = 0; par_err = 1; re = 1; step();
    reg_wr = 0; par_err = 0;
    chk("R4 set wins", per, 1'b1);
    do_read(); do_write(0);
    chk("R4 final clear", per, 1'b0);

    // R6 forced tend while te=0
    te = 0; err_sig = 0; step();
    chk("R6 force", tend, 1'b1);
    te = 1; tdr_wr = 1; step(); tdr_wr = 0;
    chk("R7 clear on write", tend, 1'b0);
    te = 0; err_sig = 1; step(); step();
    chk("R6 no force with err", tend, 1'b0);
    err_sig = 0; step();
    chk("R6 force after err drops", tend, 1'b1);

    // R8/R9 sweep over modes and conditions
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        int n;
        logic ok;
        gm = m[1]; blk = m[0];
        n = gm ? 2 : (blk ? 3 : 5);
        ok = c[0] && !c[1];
        te = 1; err_sig = 0; tdr_wr = 1; step(); tdr_wr = 0;
        chk("R7 clear", tend, 1'b0);
        tdr_empty = c[0]; err_sig = c[1];
        tx_done = 1; step(); tx_done = 0;
        gm = ~gm; blk = ~blk;  // later changes must not matter
        for (int k = 1; k <= n; k++) begin
          half_tick = 1; step(); half_tick = 0;
          if (k == n) chk("R9 tend at expiry", tend, ok);
          else chk("R8 tend early", tend, 1'b0);
          step();
        end
        err_sig = 0; tdr_empty = 0;
      end
    end

    // R10 reset mid-operation
    raise_per();
    te = 1; tdr_wr = 1; step(); tdr_wr = 0;
    rst = 1; step(); rst = 0;
    chk("R10 per after rst", per, 1'b0);
    chk("R10 tend after rst", tend, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule